// File: doc/BRIEF.md
# Programmable Logic Block Term Array and Allocator

This block is the combinational core of one logic block in a programmable logic device. Thirty-six routed signals come in. Each signal is offered to a programmable AND plane in two forms, as itself and as its inverse, which gives 72 literals. The plane forms 87 product terms. Eighty of them are general terms, and an allocator hands them to the OR inputs of sixteen macrocells. The other seven are control terms: four output-enable terms, an asynchronous set term, an asynchronous reset term and a clock term. Each control term has its own invert bit.

The allocator splits the cells into groups of four. Each group owns twenty consecutive general terms. Each cell sees a fixed window of sixteen terms inside its group's pool, and one mask bit per window slot chooses which terms that cell ORs together. The windows of neighbouring cells overlap, so a single term can feed several cells of one group. A cell can take anywhere from zero to sixteen terms.

The configuration is one long vector. It is cleared by reset and shifted in one bit per clock while the load enable is high. At all other times it holds. The macrocell flip-flops and the global routing belong to other blocks.

Top module: `ptLogicBlock`

## Requirements
- R1: Configuration bit t*72+l enables literal l in product term t. Literal 2i is input i, and literal 2i+1 is the inverse of input i. A term is 1 when every literal it enables is 1.
- R2: A product term with no literal enabled evaluates to 1.
- R3: A product term that enables both forms of one input evaluates to 0.
- R4: Cell c = 4g+k (k from 0 to 3) sees the general terms 20g+start(k)+s for s from 0 to 15, where start is 0, 1, 2, 4 for k = 0, 1, 2, 3. Mask bit 6264+16c+s adds slot s to the OR that drives cellSum[c].
- R5: A cell whose sixteen mask bits are all 0 drives cellSum 0.
- R6: A general term that falls in the windows of several cells of one group can drive all of those cells at the same time.
- R7: Cells 8 to 15 take output-enable term 80 when their select bit (6520+c) is 0 and term 81 when it is 1. Cells 0 to 7 take term 82 or term 83 in the same way. Invert bits 6536+0 to 6536+3 apply to terms 80 to 83.
- R8: setOut, resetOut and clkOut are terms 84, 85 and 86. Each is XORed with its invert bit, at 6540, 6541 and 6542.
- R9: While cfgEn is high, each rising clock edge shifts cfgBit into bit 0 and moves every other bit up by one. After 6543 shifts, the first bit sent sits at bit 6542.
- R10: While cfgEn is low, the configuration holds and cfgBit has no effect.
- R11: Reset clears the configuration. After reset, every cellSum is 0, every cellOe is 1, and setOut, resetOut and clkOut are all 1.
- R12: The outputs depend only on inVec and the stored configuration, and they follow inVec with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset; clears the configuration |
| cfgEn | input | 1 | Shift enable for the configuration |
| cfgBit | input | 1 | Serial configuration data |
| inVec | input | 36 | Routed input signals |
| cellSum | output | 16 | Per-cell OR of the steered terms |
| cellOe | output | 16 | Per-cell output-enable |
| setOut | output | 1 | Asynchronous set control term |
| resetOut | output | 1 | Asynchronous reset control term |
| clkOut | output | 1 | Product-term clock |

## Verification
The assertions assume that reset is asserted before any configuration is loaded. They also assume that cfgEn and inVec change only away from the clock edge, so that a stable configuration paired with stable inputs means stable outputs. The stimulus follows both assumptions. Every input is driven on the falling edge, configurations are loaded only after reset, and each output is sampled one nanosecond after the inputs change. The hold check toggles cfgBit with cfgEn low.

// File: rtl/ptPkg.sv
package ptPkg;
  typedef struct packed {
    logic shift;
    logic clear;
  } cfgStrobe_t;

  localparam int POL_SET = 4;
  localparam int POL_RST = 5;
  localparam int POL_CLK = 6;
  localparam int NUM_CTRL = 7;
endpackage

// File: rtl/ptCtl.sv
module ptCtl (
  input  logic             rst,
  input  logic             cfgEn,
  output ptPkg::cfgStrobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.shift = cfgEn & ~rst;
  end
endmodule

// File: rtl/ptCfgStore.sv
module ptCfgStore #(
  parameter int CFG_W = 8
) (
  input  logic              clk,
  input  ptPkg::cfgStrobe_t strobe,
  input  logic              cfgBit,
  output logic [CFG_W-1:0]  cfgVec
);
  always_ff @(posedge clk) begin
    if (strobe.clear)      cfgVec <= '0;
    else if (strobe.shift) cfgVec <= {cfgVec[CFG_W-2:0], cfgBit};
  end
endmodule

// File: rtl/ptArray.sv
module ptArray #(
  parameter int NUM_IN = 36,
  parameter int NUM_PT = 87,
  localparam int NUM_LIT = 2 * NUM_IN
) (
  input  logic [NUM_IN-1:0]         inVec,
  input  logic [NUM_PT*NUM_LIT-1:0] andMask,
  output logic [NUM_PT-1:0]         terms
);
  logic [NUM_LIT-1:0] lits;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign lits[2*i]   = inVec[i];
    assign lits[2*i+1] = ~inVec[i];
  end

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    assign terms[t] = &(lits | ~andMask[t*NUM_LIT +: NUM_LIT]);
  end
endmodule

// File: rtl/ptAlloc.sv
module ptAlloc #(
  parameter int NUM_CELLS  = 16,
  parameter int GROUP_SIZE = 4,
  parameter int GROUP_PT   = 20,
  parameter int WINDOW     = 16,
  localparam int NUM_GEN   = (NUM_CELLS / GROUP_SIZE) * GROUP_PT,
  localparam int NUM_PT    = NUM_GEN + ptPkg::NUM_CTRL
) (
  input  logic [NUM_PT-1:0]           terms,
  input  logic [NUM_CELLS*WINDOW-1:0] steer,
  input  logic [NUM_CELLS-1:0]        oeSel,
  input  logic [ptPkg::NUM_CTRL-1:0]  pol,
  output logic [NUM_CELLS-1:0]        cellSum,
  output logic [NUM_CELLS-1:0]        cellOe,
  output logic                        setOut,
  output logic                        resetOut,
  output logic                        clkOut
);
  localparam int SPREAD = GROUP_PT - WINDOW;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam int GRP   = c / GROUP_SIZE;
    localparam int POS   = c % GROUP_SIZE;
    localparam int START = (GROUP_SIZE > 1) ? (POS * SPREAD) / (GROUP_SIZE - 1) : 0;
    localparam int BASE  = GRP * GROUP_PT + START;
    localparam int OEIDX = (c >= NUM_CELLS / 2) ? 0 : 2;

    assign cellSum[c] = |(terms[BASE +: WINDOW] & steer[c*WINDOW +: WINDOW]);
    assign cellOe[c]  = oeSel[c] ? (terms[NUM_GEN+OEIDX+1] ^ pol[OEIDX+1])
                                 : (terms[NUM_GEN+OEIDX]   ^ pol[OEIDX]);
  end

  assign setOut   = terms[NUM_GEN+ptPkg::POL_SET] ^ pol[ptPkg::POL_SET];
  assign resetOut = terms[NUM_GEN+ptPkg::POL_RST] ^ pol[ptPkg::POL_RST];
  assign clkOut   = terms[NUM_GEN+ptPkg::POL_CLK] ^ pol[ptPkg::POL_CLK];
endmodule

// File: rtl/ptLogicBlock.sv
module ptLogicBlock #(
  parameter int NUM_IN     = 36,
  parameter int NUM_CELLS  = 16,
  parameter int GROUP_SIZE = 4,
  parameter int GROUP_PT   = 20,
  parameter int WINDOW     = 16,
  localparam int NUM_LIT   = 2 * NUM_IN,
  localparam int NUM_GEN   = (NUM_CELLS / GROUP_SIZE) * GROUP_PT,
  localparam int NUM_PT    = NUM_GEN + ptPkg::NUM_CTRL,
  localparam int AND_BITS  = NUM_PT * NUM_LIT,
  localparam int STEER_BITS = NUM_CELLS * WINDOW,
  localparam int CFG_W     = AND_BITS + STEER_BITS + NUM_CELLS + ptPkg::NUM_CTRL
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgEn,
  input  logic                 cfgBit,
  input  logic [NUM_IN-1:0]    inVec,
  output logic [NUM_CELLS-1:0] cellSum,
  output logic [NUM_CELLS-1:0] cellOe,
  output logic                 setOut,
  output logic                 resetOut,
  output logic                 clkOut
);
  ptPkg::cfgStrobe_t strobe;
  logic [CFG_W-1:0]  cfgVec;
  logic [NUM_PT-1:0] terms;

  ptCtl u_ctl (.rst(rst), .cfgEn(cfgEn), .strobe(strobe));

  ptCfgStore #(.CFG_W(CFG_W)) u_store (
    .clk(clk), .strobe(strobe), .cfgBit(cfgBit), .cfgVec(cfgVec));

  ptArray #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) u_array (
    .inVec(inVec), .andMask(cfgVec[AND_BITS-1:0]), .terms(terms));

  ptAlloc #(.NUM_CELLS(NUM_CELLS), .GROUP_SIZE(GROUP_SIZE),
            .GROUP_PT(GROUP_PT), .WINDOW(WINDOW)) u_alloc (
    .terms(terms),
    .steer(cfgVec[AND_BITS +: STEER_BITS]),
    .oeSel(cfgVec[AND_BITS+STEER_BITS +: NUM_CELLS]),
    .pol(cfgVec[CFG_W-1 -: ptPkg::NUM_CTRL]),
    .cellSum(cellSum), .cellOe(cellOe),
    .setOut(setOut), .resetOut(resetOut), .clkOut(clkOut));
endmodule

// File: rtl/ptChecker.sv
module ptChecker #(
  parameter int NUM_IN    = 36,
  parameter int NUM_CELLS = 16,
  parameter int WINDOW    = 16,
  parameter int AND_BITS  = 6264,
  parameter int CFG_W     = 6543
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfgEn,
  input logic [NUM_IN-1:0]    inVec,
  input logic [CFG_W-1:0]     cfgVec,
  input logic [NUM_CELLS-1:0] cellSum,
  input logic [NUM_CELLS-1:0] cellOe,
  input logic                 setOut,
  input logic                 resetOut,
  input logic                 clkOut
);
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(cfgEn) && !$past(rst) |-> $stable(cfgVec));

  assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cellSum == '0) && (cellOe == {NUM_CELLS{1'b1}})
                   && setOut && resetOut && clkOut);

  assert_comb_follow_R12: assert property (@(posedge clk) disable iff (rst)
    $stable(inVec) && $stable(cfgVec) |->
      $stable(cellSum) && $stable(cellOe) && $stable({setOut, resetOut, clkOut}));

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
    assert_empty_cell_R5: assert property (@(posedge clk) disable iff (rst)
      (cfgVec[AND_BITS + c*WINDOW +: WINDOW] == '0) |-> !cellSum[c]);
  end
endmodule

bind ptLogicBlock ptChecker #(
  .NUM_IN(NUM_IN), .NUM_CELLS(NUM_CELLS), .WINDOW(WINDOW),
  .AND_BITS(AND_BITS), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst(rst), .cfgEn(cfgEn), .inVec(inVec), .cfgVec(cfgVec),
  .cellSum(cellSum), .cellOe(cellOe), .setOut(setOut),
  .resetOut(resetOut), .clkOut(clkOut));

// File: tb/tb_ptLogicBlock.sv
module tb_ptLogicBlock;
  localparam int NL = 72;
  localparam int AB = 87 * NL;
  localparam int SB = 16 * 16;
  localparam int OB = AB + SB;
  localparam int PB = OB + 16;
  localparam int CW = PB + 7;

  typedef struct packed {
    logic [35:0] in;
    logic [15:0] sum;
    logic [15:0] oe;
    logic [2:0]  ctl;
  } vec_t;

  localparam vec_t TABLE [7] = '{
    '{36'h0_0000_0000, 16'h0007, 16'h02FF, 3'b010},
    '{36'h8_0000_0001, 16'h0014, 16'h02FF, 3'b010},
    '{36'h0_0000_001B, 16'h0005, 16'hFD02, 3'b010},
    '{36'h0_0000_00E0, 16'h0007, 16'h02FF, 3'b100},
    '{36'h0_0000_0024, 16'h0007, 16'h02FF, 3'b010},
    '{36'hF_FFFF_FFFF, 16'h0015, 16'hFD02, 3'b100},
    '{36'h7_FFFF_FF00, 16'h0007, 16'h02FF, 3'b010}
  };

  logic clk = 0, rst = 1, cfgEn = 0, cfgBit = 0;
  logic [35:0] inVec = '0;
  logic [15:0] cellSum, cellOe;
  logic setOut, resetOut, clkOut;
  logic [CW-1:0] img;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptLogicBlock dut (.clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .inVec(inVec), .cellSum(cellSum), .cellOe(cellOe), .setOut(setOut),
    .resetOut(resetOut), .clkOut(clkOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadCfg();
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk); cfgEn = 1; cfgBit = img[i];
    end
    @(negedge clk); cfgEn = 0; cfgBit = 0;
  endtask

  task automatic apply(input logic [35:0] v);
    @(negedge clk); inVec = v; #1;
  endtask

  task automatic checkReset();
    check("R11 sum", 32'(cellSum), 32'h0);
    check("R11 oe", 32'(cellOe), 32'hFFFF);
    check("R11 ctl", 32'({setOut, resetOut, clkOut}), 32'h7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    apply(36'hF_FFFF_FFFF);
    checkReset();

    // Config A: R1 R2 R3 R6 R7 R8
    img = '0;
    img[0*NL+0] = 1; img[0*NL+2] = 1;      // t0 = in0 & in1
    img[1*NL+1] = 1;                       // t1 = ~in0
    img[4*NL+4] = 1; img[4*NL+5] = 1;      // t4 = in2 & ~in2 (R3)
    img[20*NL+70] = 1;                     // t20 = in35
    img[80*NL+6] = 1; img[81*NL+7] = 1; img[82*NL+8] = 1;
    img[84*NL+10] = 1; img[84*NL+12] = 1;  // set = in5 & in6
    img[85*NL+14] = 1;                     // reset = ~in7 after invert
    img[AB+0*16+0] = 1; img[AB+0*16+1] = 1;
    img[AB+1*16+0] = 1;                    // shares t1 with cell0 (R6)
    img[AB+2*16+0] = 1; img[AB+2*16+2] = 1;// empty t2 (R2) | t4
    img[AB+3*16+0] = 1;                    // t4 only
    img[AB+4*16+0] = 1;
    img[OB+1] = 1; img[OB+9] = 1;
    img[PB+2] = 1; img[PB+5] = 1; img[PB+6] = 1;
    loadCfg();

    foreach (TABLE[i]) begin
      apply(TABLE[i].in);
      check("R4 sum", 32'(cellSum), 32'(TABLE[i].sum));
      check("R7 oe", 32'(cellOe), 32'(TABLE[i].oe));
      check("R8 ctl", 32'({setOut, resetOut, clkOut}), 32'(TABLE[i].ctl));
    end
    check("R1 R9 loaded", 32'(cellSum[0]), 32'h1);

    // R10: cfgBit toggles with cfgEn low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); cfgBit = ~cfgBit;
    end
    apply(TABLE[2].in);
    check("R10 sum", 32'(cellSum), 32'(TABLE[2].sum));
    check("R10 oe", 32'(cellOe), 32'(TABLE[2].oe));

    // R12: outputs follow input with no clock edge
    @(negedge clk); inVec = TABLE[1].in; #0.5;
    check("R12 sum", 32'(cellSum), 32'(TABLE[1].sum));

    // R11: reset clears configuration
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
    checkReset();

    // Config B: window starts (R4), empty cells (R5)
    img = '0;
    img[79*NL+20] = 1;                     // t79 = in10
    img[AB+3*16+0] = 1;                    // cell3 slot0 = t4 (empty -> 1)
    img[AB+15*16+15] = 1;                  // cell15 slot15 = t79
    loadCfg();
    apply(36'h0);
    check("R4 start", 32'(cellSum), 32'h0008);
    apply(36'h0_0000_0400);
    check("R4 last", 32'(cellSum), 32'h8008);
    apply(36'hF_FFFF_FBFF);
    check("R5 empty", 32'(cellSum), 32'h0008);
    check("R8 default", 32'({setOut, resetOut, clkOut}), 32'h7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule